// File: doc/BRIEF.md
# Character Row Display Fetch Engine

This block drives a text-mode raster for an 800x600 VGA timing grid. It runs on the 40 MHz dot clock and processes one dot per clock. A cell of 16 dots is one system cycle, and each cell shows eight glyph pixels. Every glyph pixel is doubled in both directions, so the 640x400 active window holds 40 columns by 25 rows of 8x8 characters. A border fills the space between the active window and the visible edge.

On the first scan line of each character row, the block takes over the processor's memory slot. It raises `cpuStall` and reads that row's character codes from screen memory into an internal line buffer. On every scan line of the row, including that first one, it reads one glyph byte per column from the character generator. The glyph address is formed from the buffered code and the current line within the character. The glyph byte is loaded into a shifter one cell ahead of where it is shown. Each code read is placed two cells ahead of its column's pixels, so column 0 is ready before the left border ends.

Both memory ports follow the same read rule. The block raises a read strobe for one clock. The memory must return the byte on the next clock edge and hold it until the next read. The block picks up the byte one clock after that.

Top module: `chardisp_dma`

## Requirements
- R1: While `rst` is high, `rgb`, `hSync`, `vSync`, `cpuStall`, `codeRd` and `glyphRd` are all 0.
- R2: The dot at horizontal position h and line v of the frame is processed on one clock. Its `rgb`, `hSync`, `vSync` and `cpuStall` values appear right after that clock's edge. Dot (0,0) is processed on the first clock after reset is released. `hSync` is high for h in [H_VIS+H_FP, H_VIS+H_FP+H_SYNC). `vSync` is high for v in [V_VIS+V_FP, V_VIS+V_FP+V_SYNC). Both syncs are active high.
- R3: Outside the visible area (h ≥ H_VIS or v ≥ V_VIS), `rgb` is 0. Inside the visible area but outside the active window, `rgb` equals `BG_RGB`.
- R4: Inside the active window, a cell shows glyph bits 7 down to 0 in order, each for PIX_REP dots. A 1 bit shows `FG_RGB` and a 0 bit shows `BG_RGB`.
- R5: The row-within-character is ((v − ACT_Y0) / PIX_REP) mod 8, so each glyph line is repeated on PIX_REP scan lines. A character row spans 8·PIX_REP lines.
- R6: On the first scan line of character row r, column c's code is read from SCREEN_BASE + r·COLS + c. That read is issued at dot (A−2+c)·CELL, where A = ACT_X0/CELL.
- R7: On every line of the active window, column c's glyph is read from CHARGEN_BASE + 8·code + row-within-character. That read is issued at dot (A−1+c)·CELL.
- R8: Codes are read only on a row's first scan line. A change to screen memory after that line does not appear until the next row that reads the changed location.
- R9: On each row's first scan line, `cpuStall` is high for dots A−3 cells through (A+COLS−3)·CELL+1, and low elsewhere. It rises one system cycle before the first code read and falls when the last code is captured. Every code read falls inside this window.
- R10: On a row's first scan line, column 0 shows its own glyph for that line. It shows neither a neighbour's code nor stale buffer contents.
- R11: `codeRd` and `glyphRd` are single-clock pulses. Exactly one of each is issued per column on the lines named in R6 and R7, and none at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz dot clock |
| rst | input | 1 | Synchronous reset, active high |
| codeRd | output | 1 | Screen-memory read strobe (processor slot) |
| codeAddr | output | ADDR_W | Screen-memory read address |
| codeData | input | 8 | Character code returned by memory |
| glyphRd | output | 1 | Character-generator read strobe (video slot) |
| glyphAddr | output | ADDR_W | Character-generator read address |
| glyphData | input | 8 | Glyph byte returned by memory |
| cpuStall | output | 1 | Holds the processor off the bus during code fetch |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| rgb | output | 12 | Pixel colour, 4 bits per channel |

## Verification
The properties take the memory side to be a plain one-clock read port: it returns a byte on the clock after a strobe and holds it until the next strobe. They also assume the timing parameters leave at least three cells of left border and make the line length a whole number of cells. The bench memory model honours this read rule exactly, and its reduced-size geometry keeps the same three-cell lead. Screen memory is rewritten only in the middle of a character row or during vertical blanking, never while a row's codes are being read. This way every expected code is well defined when the bench snapshots it.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  // One-bit strobes passed from the timing control to the datapath.
  typedef struct packed {
    logic codeFetch;   // issue a screen-memory read
    logic codeStore;   // capture returned code into the line buffer
    logic glyphFetch;  // issue a character-generator read
    logic shiftLoad;   // load next glyph byte into the pixel shifter
    logic shiftStep;   // advance the shifter by one glyph pixel
    logic stallSet;    // start holding the processor
    logic stallClr;    // release the processor
    logic pixActive;   // dot lies in the character window
    logic pixVisible;  // dot lies in the visible area
    logic hsOn;        // dot lies in horizontal sync
    logic vsOn;        // line lies in vertical sync
  } dispStrobes_t;

endpackage

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
  import chardisp_pkg::*;
#(
  parameter int PIX_REP = 2,
  parameter int H_VIS   = 800,
  parameter int H_FP    = 40,
  parameter int H_SYNC  = 128,
  parameter int H_BP    = 88,
  parameter int V_VIS   = 600,
  parameter int V_FP    = 1,
  parameter int V_SYNC  = 4,
  parameter int V_BP    = 23,
  parameter int ACT_X0  = 80,
  parameter int ACT_Y0  = 100,
  parameter int COLS    = 40,
  parameter int ROWS    = 25,
  parameter int COL_W   = 6,
  parameter int ROW_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  output dispStrobes_t     strb,
  output logic [COL_W-1:0] codeCol,
  output logic [COL_W-1:0] glyphCol,
  output logic [ROW_W-1:0] rowIdx,
  output logic [2:0]       lineInChar
);

  localparam int CELL      = 8 * PIX_REP;
  localparam int H_TOTAL   = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL   = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int ROW_LINES = 8 * PIX_REP;
  localparam int ACT_X1    = ACT_X0 + COLS * CELL;
  localparam int ACT_Y1    = ACT_Y0 + ROWS * ROW_LINES;
  localparam int CELL0     = ACT_X0 / CELL;
  localparam int HW        = $clog2(H_TOTAL);
  localparam int VW        = $clog2(V_TOTAL);
  localparam int CPW       = $clog2(CELL);
  localparam int CIW       = $clog2(H_TOTAL / CELL + 1);

  logic [HW-1:0]  hDot;
  logic [VW-1:0]  vLine;
  logic [CPW-1:0] cellPh;
  logic [CIW-1:0] cellIdx;

  // Raster position counters; the cell phase and index track hDot.
  always_ff @(posedge clk) begin
    if (rst) begin
      hDot    <= '0;
      vLine   <= '0;
      cellPh  <= '0;
      cellIdx <= '0;
    end else if (hDot == HW'(H_TOTAL - 1)) begin
      hDot    <= '0;
      cellPh  <= '0;
      cellIdx <= '0;
      vLine   <= (vLine == VW'(V_TOTAL - 1)) ? '0 : vLine + VW'(1);
    end else begin
      hDot <= hDot + HW'(1);
      if (cellPh == CPW'(CELL - 1)) begin
        cellPh  <= '0;
        cellIdx <= cellIdx + CIW'(1);
      end else begin
        cellPh <= cellPh + CPW'(1);
      end
    end
  end

  int hI, vI, phI, ciI, lrI;
  assign hI  = int'(hDot);
  assign vI  = int'(vLine);
  assign phI = int'(cellPh);
  assign ciI = int'(cellIdx);
  assign lrI = vI - ACT_Y0;

  logic vAct, badLine, codeWin, glyphWin;

  always_comb begin
    vAct     = (vI >= ACT_Y0) && (vI < ACT_Y1);
    badLine  = vAct && ((lrI % ROW_LINES) == 0);
    codeWin  = (ciI >= CELL0 - 2) && (ciI < CELL0 - 2 + COLS);
    glyphWin = (ciI >= CELL0 - 1) && (ciI < CELL0 - 1 + COLS);

    strb            = '0;
    strb.codeFetch  = badLine && codeWin && (phI == 0);
    strb.codeStore  = badLine && codeWin && (phI == 2);
    strb.glyphFetch = vAct && glyphWin && (phI == 0);
    strb.shiftLoad  = (phI == CELL - 1);
    strb.shiftStep  = ((phI % PIX_REP) == PIX_REP - 1);
    strb.stallSet   = badLine && (ciI == CELL0 - 3) && (phI == 0);
    strb.stallClr   = badLine && (ciI == CELL0 + COLS - 3) && (phI == 2);
    strb.pixActive  = vAct && (hI >= ACT_X0) && (hI < ACT_X1);
    strb.pixVisible = (hI < H_VIS) && (vI < V_VIS);
    strb.hsOn       = (hI >= H_VIS + H_FP) && (hI < H_VIS + H_FP + H_SYNC);
    strb.vsOn       = (vI >= V_VIS + V_FP) && (vI < V_VIS + V_FP + V_SYNC);
  end

  // Column being fetched this cell; the code stream leads glyphs by one cell.
  assign codeCol    = COL_W'(ciI - (CELL0 - 2));
  assign glyphCol   = COL_W'(ciI - (CELL0 - 1));
  assign rowIdx     = vAct ? ROW_W'(lrI / ROW_LINES) : '0;
  assign lineInChar = 3'((lrI / PIX_REP) % 8);

endmodule

// File: rtl/chardisp_datapath.sv
module chardisp_datapath
  import chardisp_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          COLS         = 40,
  parameter int          COL_W        = 6,
  parameter int          ROW_W        = 5,
  parameter int          SCREEN_BASE  = 'h0400,
  parameter int          CHARGEN_BASE = 'h1000,
  parameter logic [11:0] FG_RGB       = 12'hFFF,
  parameter logic [11:0] BG_RGB       = 12'h22A
) (
  input  logic              clk,
  input  logic              rst,
  input  dispStrobes_t      strb,
  input  logic [COL_W-1:0]  codeCol,
  input  logic [COL_W-1:0]  glyphCol,
  input  logic [ROW_W-1:0]  rowIdx,
  input  logic [2:0]        lineInChar,
  input  logic [7:0]        codeData,
  input  logic [7:0]        glyphData,
  output logic              codeRd,
  output logic [ADDR_W-1:0] codeAddr,
  output logic              glyphRd,
  output logic [ADDR_W-1:0] glyphAddr,
  output logic              cpuStall,
  output logic              hSync,
  output logic              vSync,
  output logic [11:0]       rgb
);

  logic [7:0] lineBuf [COLS];
  logic [7:0] pixShift;

  // Line buffer: one code per column, refilled on each row's first line.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < COLS; i++) lineBuf[i] <= '0;
    end else if (strb.codeStore) begin
      lineBuf[codeCol] <= codeData;
    end
  end

  // Memory request issue.
  always_ff @(posedge clk) begin
    if (rst) begin
      codeRd    <= 1'b0;
      codeAddr  <= '0;
      glyphRd   <= 1'b0;
      glyphAddr <= '0;
    end else begin
      codeRd  <= strb.codeFetch;
      glyphRd <= strb.glyphFetch;
      if (strb.codeFetch)
        codeAddr <= ADDR_W'(SCREEN_BASE + int'(rowIdx) * COLS + int'(codeCol));
      if (strb.glyphFetch)
        glyphAddr <= ADDR_W'(CHARGEN_BASE + int'(lineBuf[glyphCol]) * 8
                             + int'(lineInChar));
    end
  end

  // Processor hold window.
  always_ff @(posedge clk) begin
    if (rst)                cpuStall <= 1'b0;
    else if (strb.stallSet) cpuStall <= 1'b1;
    else if (strb.stallClr) cpuStall <= 1'b0;
  end

  // Pixel shifter and registered video outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      pixShift <= '0;
      hSync    <= 1'b0;
      vSync    <= 1'b0;
      rgb      <= '0;
    end else begin
      if (strb.shiftLoad)      pixShift <= glyphData;
      else if (strb.shiftStep) pixShift <= {pixShift[6:0], 1'b0};
      hSync <= strb.hsOn;
      vSync <= strb.vsOn;
      if (!strb.pixVisible)                    rgb <= '0;
      else if (strb.pixActive && pixShift[7])  rgb <= FG_RGB;
      else                                     rgb <= BG_RGB;
    end
  end

endmodule

// File: rtl/chardisp_dma.sv
module chardisp_dma
  import chardisp_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          SCREEN_BASE  = 'h0400,
  parameter int          CHARGEN_BASE = 'h1000,
  parameter int          PIX_REP      = 2,
  parameter int          H_VIS        = 800,
  parameter int          H_FP         = 40,
  parameter int          H_SYNC       = 128,
  parameter int          H_BP         = 88,
  parameter int          V_VIS        = 600,
  parameter int          V_FP         = 1,
  parameter int          V_SYNC       = 4,
  parameter int          V_BP         = 23,
  parameter int          ACT_X0       = 80,
  parameter int          ACT_Y0       = 100,
  parameter int          COLS         = 40,
  parameter int          ROWS         = 25,
  parameter logic [11:0] FG_RGB       = 12'hFFF,
  parameter logic [11:0] BG_RGB       = 12'h22A
) (
  input  logic              clk,
  input  logic              rst,
  output logic              codeRd,
  output logic [ADDR_W-1:0] codeAddr,
  input  logic [7:0]        codeData,
  output logic              glyphRd,
  output logic [ADDR_W-1:0] glyphAddr,
  input  logic [7:0]        glyphData,
  output logic              cpuStall,
  output logic              hSync,
  output logic              vSync,
  output logic [11:0]       rgb
);

  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  dispStrobes_t     strb;
  logic [COL_W-1:0] codeCol, glyphCol;
  logic [ROW_W-1:0] rowIdx;
  logic [2:0]       lineInChar;

  chardisp_ctrl #(
    .PIX_REP(PIX_REP), .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .ACT_X0(ACT_X0), .ACT_Y0(ACT_Y0), .COLS(COLS), .ROWS(ROWS),
    .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .strb(strb), .codeCol(codeCol), .glyphCol(glyphCol),
    .rowIdx(rowIdx), .lineInChar(lineInChar)
  );

  chardisp_datapath #(
    .ADDR_W(ADDR_W), .COLS(COLS), .COL_W(COL_W), .ROW_W(ROW_W),
    .SCREEN_BASE(SCREEN_BASE), .CHARGEN_BASE(CHARGEN_BASE),
    .FG_RGB(FG_RGB), .BG_RGB(BG_RGB)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .codeCol(codeCol), .glyphCol(glyphCol),
    .rowIdx(rowIdx), .lineInChar(lineInChar), .codeData(codeData),
    .glyphData(glyphData), .codeRd(codeRd), .codeAddr(codeAddr),
    .glyphRd(glyphRd), .glyphAddr(glyphAddr), .cpuStall(cpuStall),
    .hSync(hSync), .vSync(vSync), .rgb(rgb)
  );

endmodule

// File: rtl/chardisp_dma_chk.sv
module chardisp_dma_chk #(
  parameter int ADDR_W       = 16,
  parameter int SCREEN_BASE  = 'h0400,
  parameter int CHARGEN_BASE = 'h1000,
  parameter int COLS         = 40,
  parameter int ROWS         = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              codeRd,
  input logic [ADDR_W-1:0] codeAddr,
  input logic              glyphRd,
  input logic [ADDR_W-1:0] glyphAddr,
  input logic              cpuStall,
  input logic              hSync,
  input logic              vSync,
  input logic [11:0]       rgb
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!codeRd && !glyphRd && !cpuStall && rgb == 12'h000));

  assert_code_in_stall_R9: assert property (@(posedge clk) disable iff (rst)
    codeRd |-> cpuStall);

  assert_stall_leads_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cpuStall) |-> !codeRd);

  assert_code_range_R6: assert property (@(posedge clk) disable iff (rst)
    codeRd |-> (int'(codeAddr) >= SCREEN_BASE &&
                int'(codeAddr) <  SCREEN_BASE + COLS * ROWS));

  assert_glyph_range_R7: assert property (@(posedge clk) disable iff (rst)
    glyphRd |-> (int'(glyphAddr) >= CHARGEN_BASE &&
                 int'(glyphAddr) <  CHARGEN_BASE + 2048));

  assert_blank_dark_R3: assert property (@(posedge clk) disable iff (rst)
    (hSync || vSync) |-> rgb == 12'h000);

  assert_code_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    codeRd |=> !codeRd);

  assert_glyph_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    glyphRd |=> !glyphRd);

endmodule

bind chardisp_dma chardisp_dma_chk #(
  .ADDR_W(ADDR_W), .SCREEN_BASE(SCREEN_BASE), .CHARGEN_BASE(CHARGEN_BASE),
  .COLS(COLS), .ROWS(ROWS)
) u_chk (
  .clk(clk), .rst(rst), .codeRd(codeRd), .codeAddr(codeAddr),
  .glyphRd(glyphRd), .glyphAddr(glyphAddr), .cpuStall(cpuStall),
  .hSync(hSync), .vSync(vSync), .rgb(rgb)
);

// File: tb/chardisp_dma_tb.sv
module chardisp_dma_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 13;
  localparam int SCR     = 'h0400;
  localparam int CGEN    = 'h1000;
  localparam int PIX_REP = 2;
  localparam int CELL    = 8 * PIX_REP;
  localparam int H_VIS = 128, H_FP = 16, H_SYNC = 16, H_BP = 16;
  localparam int V_VIS = 36,  V_FP = 1,  V_SYNC = 2,  V_BP = 1;
  localparam int ACT_X0 = 48, ACT_Y0 = 2, COLS = 4, ROWS = 2;
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int RL      = 8 * PIX_REP;
  localparam int CELL0   = ACT_X0 / CELL;
  localparam logic [11:0] FG = 12'hEC1;
  localparam logic [11:0] BG = 12'h118;
  localparam int WATCHDOG = 60000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic codeRd, glyphRd, cpuStall, hSync, vSync;
  logic [ADDR_W-1:0] codeAddr, glyphAddr;
  logic [7:0] codeData = '0, glyphData = '0;
  logic [11:0] rgb;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chardisp_dma #(
    .ADDR_W(ADDR_W), .SCREEN_BASE(SCR), .CHARGEN_BASE(CGEN), .PIX_REP(PIX_REP),
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .ACT_X0(ACT_X0), .ACT_Y0(ACT_Y0), .COLS(COLS), .ROWS(ROWS),
    .FG_RGB(FG), .BG_RGB(BG)
  ) u_dut (
    .clk(clk), .rst(rst), .codeRd(codeRd), .codeAddr(codeAddr),
    .codeData(codeData), .glyphRd(glyphRd), .glyphAddr(glyphAddr),
    .glyphData(glyphData), .cpuStall(cpuStall), .hSync(hSync),
    .vSync(vSync), .rgb(rgb)
  );

  // Memory model: one-clock read latency, data held until the next read.
  logic [7:0] mem [0:(1<<ADDR_W)-1];
  always @(posedge clk) begin
    if (codeRd)  codeData  <= mem[codeAddr];
    if (glyphRd) glyphData <= mem[glyphAddr];
  end

  typedef struct {
    int h; int v;
    logic [11:0] rgb; logic [1:0] sync; logic stall;
    logic cRd; int cAddr; logic gRd; int gAddr;
    string pixTag;
  } exp_t;

  exp_t expQ[$];
  int nChecks = 0, nBad = 0;
  int bH = 0, bV = 0, bFrame = 0;
  bit running = 0;
  logic [7:0] snap [COLS];

  function automatic logic [7:0] glyphByte(int code, int line);
    return 8'((code * 29 + line * 53 + 7) ^ (line * 16));
  endfunction

  task automatic checkVal(string tag, string what, int h, int v,
                          logic [31:0] got, logic [31:0] want);
    nChecks++;
    if (got !== want) begin
      nBad++;
      $display("FAIL %s %s at h=%0d v=%0d actual=%0h expected=%0h",
               tag, what, h, v, got, want);
    end
  endtask

  // Driver: expected outputs for the dot processed on this clock.
  task automatic pushDot(int h, int v);
    exp_t e;
    int lr, col, bi, lic, row;
    bit vAct, bad, act;
    e.h = h; e.v = v;
    lr   = v - ACT_Y0;
    vAct = (v >= ACT_Y0) && (v < ACT_Y0 + ROWS * RL);
    bad  = vAct && (lr % RL == 0);
    row  = vAct ? lr / RL : 0;
    lic  = (lr / PIX_REP) % 8;
    if (bad && h == 0)
      for (int c = 0; c < COLS; c++) snap[c] = mem[SCR + row * COLS + c];
    act = vAct && (h >= ACT_X0) && (h < ACT_X0 + COLS * CELL);
    e.pixTag = "R3";
    if (h >= H_VIS || v >= V_VIS) e.rgb = 12'h000;
    else if (!act) e.rgb = BG;
    else begin
      col = (h - ACT_X0) / CELL;
      bi  = 7 - ((h - ACT_X0) % CELL) / PIX_REP;
      e.rgb = glyphByte(int'(snap[col]), lic)[bi] ? FG : BG;
      if (col == 0 && bad) e.pixTag = "R10";
      else if (bFrame == 0 && row == 0 && lr >= 5) e.pixTag = "R8";
      else e.pixTag = "R4 R5";
    end
    e.sync = {(h >= H_VIS + H_FP) && (h < H_VIS + H_FP + H_SYNC),
              (v >= V_VIS + V_FP) && (v < V_VIS + V_FP + V_SYNC)};
    e.stall = bad && (h >= (CELL0 - 3) * CELL) && (h <= (CELL0 + COLS - 3) * CELL + 1);
    e.cRd = 1'b0; e.cAddr = 0; e.gRd = 1'b0; e.gAddr = 0;
    for (int c = 0; c < COLS; c++) begin
      if (bad && h == (CELL0 - 2 + c) * CELL) begin
        e.cRd = 1'b1; e.cAddr = SCR + row * COLS + c;
      end
      if (vAct && h == (CELL0 - 1 + c) * CELL) begin
        e.gRd = 1'b1; e.gAddr = CGEN + int'(snap[c]) * 8 + lic;
      end
    end
    expQ.push_back(e);
  endtask

  always @(posedge clk) begin
    if (running) begin
      pushDot(bH, bV);
      if (bH == H_TOTAL - 1) begin
        bH = 0;
        if (bV == V_TOTAL - 1) begin bV = 0; bFrame++; end
        else bV++;
      end else bH++;
    end
  end

  // Monitor: compare each scoreboard item against the outputs.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checkVal(e.pixTag, "rgb", e.h, e.v, 32'(rgb), 32'(e.rgb));
      checkVal("R2", "sync", e.h, e.v, 32'({hSync, vSync}), 32'(e.sync));
      checkVal("R9", "stall", e.h, e.v, 32'(cpuStall), 32'(e.stall));
      checkVal("R11", "codeRd", e.h, e.v, 32'(codeRd), 32'(e.cRd));
      checkVal("R11", "glyphRd", e.h, e.v, 32'(glyphRd), 32'(e.gRd));
      if (e.cRd) checkVal("R6", "codeAddr", e.h, e.v, 32'(codeAddr), 32'(e.cAddr));
      if (e.gRd) checkVal("R7", "glyphAddr", e.h, e.v, 32'(glyphAddr), 32'(e.gAddr));
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nBad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'h00;
    for (int c = 0; c < 256; c++)
      for (int l = 0; l < 8; l++) mem[CGEN + c * 8 + l] = glyphByte(c, l);
    // Frame 0 codes: each column distinct, column 0 unlike the last column.
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) mem[SCR + r * COLS + c] = 8'(r * 16 + c * 5 + 1);

    repeat (4) @(negedge clk);
    checkVal("R1", "rgb in reset", 0, 0, 32'(rgb), 32'h0);
    checkVal("R1", "sync in reset", 0, 0, 32'({hSync, vSync}), 32'h0);
    checkVal("R1", "stall in reset", 0, 0, 32'(cpuStall), 32'h0);
    checkVal("R1", "reads in reset", 0, 0, 32'({codeRd, glyphRd}), 32'h0);
    rst = 1'b0;
    running = 1;

    // Mid-row rewrite: row 0 must keep its buffered codes (R8), row 1 picks up the new ones.
    while (bV != ACT_Y0 + 5) @(negedge clk);
    for (int c = 0; c < COLS; c++) begin
      mem[SCR + c]        = 8'(200 + c);
      mem[SCR + COLS + c] = 8'(100 + 7 * c);
    end

    // Vertical blank: extreme code values for the second frame.
    while (bV != V_VIS + 1) @(negedge clk);
    mem[SCR + 0] = 8'hFF; mem[SCR + 1] = 8'h00; mem[SCR + 2] = 8'h80; mem[SCR + 3] = 8'h7F;
    mem[SCR + 4] = 8'h00; mem[SCR + 5] = 8'hFF; mem[SCR + 6] = 8'h01; mem[SCR + 7] = 8'hFE;

    while (bFrame < 2) @(negedge clk);
    running = 0;
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule